// File: doc/BRIEF.md
# Linear CCD Line Black-Level Estimator

This block sits behind the digitizer of a two-output linear image sensor. It receives the odd and even sample streams of one line, each sample tagged with its pixel-period position in the line. A line is 5244 periods long: 74 leading dummy periods (positions 1 to 74), then 5150 effective pixels (positions 75 to 5224), then 20 trailing dummy periods (positions 5225 to 5244). Odd positions arrive on the odd channel and even positions on the even channel.

Each channel has its own dark reference. On the odd channel the reference samples sit at the ten odd positions 5 to 23. On the even channel they sit at the ten even positions 6 to 24. The block averages these samples to form a black level for each channel. It then subtracts that level from the effective pixels of the same line, clamps the result at zero, and emits the result together with the effective pixel number. Dummy periods are never emitted. If a line ends before its reference set is complete, the levels from the previous complete line are kept.

Top module: `bl_black_est`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted sample, both output valids are low and both black-level outputs are 0.
- R2: After a complete reference set, the odd level is floor(sum/10) of the odd-channel samples at positions 5,7,...,23 of the current line. The even level is the same over the even-channel samples at positions 6,8,...,24. Positions count 1 to 5244 from the start of the line.
- R3: An accepted sample at position P, with 75 ≤ P ≤ 5224, is emitted on its own channel one clock later with output index P−74, when emission is allowed (R7).
- R4: The emitted value is the sample minus its own channel's current black level, or 0 when the sample is not larger than the level.
- R5: The block emits nothing for samples at positions 1 to 74, 5225 to 5244, 0, or above 5244. Reference samples that arrive after a channel's set of ten is complete leave its level unchanged.
- R6: A sample whose position parity does not match its channel is ignored: an odd position on the even channel, or an even position on the odd channel. Such a sample is neither emitted nor accumulated.
- R7: After a line start, no effective pixel is emitted on either channel until both channels have completed their ten reference samples in that line.
- R8: A line that ends, or is restarted, with an incomplete reference set discards its partial sum. Both black-level outputs keep the values of the last complete set.
- R9: A pulse on line_start opens a line and a pulse on line_end closes it. Samples that arrive while no line is open are ignored. A sample that arrives in the same cycle as line_start belongs to the new line. A sample that arrives in the same cycle as line_end belongs to the line being closed.
- R10: A channel's black-level output takes its new value in the clock cycle after the cycle that presents that channel's tenth reference sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_start | input | 1 | One-cycle pulse opening a line |
| line_end | input | 1 | One-cycle pulse closing a line |
| odd_valid | input | 1 | Odd-channel sample present |
| odd_idx | input | 13 | Position in line of the odd sample |
| odd_data | input | 12 | Odd sample value |
| even_valid | input | 1 | Even-channel sample present |
| even_idx | input | 13 | Position in line of the even sample |
| even_data | input | 12 | Even sample value |
| odd_out_valid | output | 1 | Corrected odd pixel present |
| odd_out_idx | output | 13 | Effective pixel number (1 to 5150) of the odd output |
| odd_out_data | output | 12 | Corrected odd pixel |
| even_out_valid | output | 1 | Corrected even pixel present |
| even_out_idx | output | 13 | Effective pixel number of the even output |
| even_out_data | output | 12 | Corrected even pixel |
| odd_black | output | 12 | Current odd-channel black level |
| even_black | output | 12 | Current even-channel black level |

## Verification
Lines with high reference values are driven so that many effective pixels fall below the level. A design that wrapped instead of clamping would then emit large values where zero is expected. Truncated lines check that a partial reference sum never reaches the level outputs, and that a fresh line without references emits nothing. A design that reused the previous line's completion would leak pixels in that case. Swapped-parity samples, samples outside an open line, out-of-range positions, trailing dummies and repeated reference positions are all fed in. A design that accumulated or emitted any of them would show a wrong level or a spurious output valid.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int NCH = 2;

  typedef enum logic {CH_ODD = 1'b0, CH_EVEN = 1'b1} chan_e;

  // parity of the positions a channel carries
  function automatic logic chan_parity(chan_e ch);
    return (ch == CH_ODD);
  endfunction
endpackage

// File: rtl/bl_rst_sync.sv
module bl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bl_ref_acc.sv
module bl_ref_acc #(
  parameter int DW    = 12,
  parameter int IW    = 13,
  parameter int N     = 10,
  parameter int FIRST = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_clr,
  input  logic          i_valid,
  input  logic [IW-1:0] i_idx,
  input  logic [DW-1:0] i_data,
  output logic [DW-1:0] o_blk,
  output logic          o_done
);
  localparam int SW = DW + $clog2(N);
  localparam int KS = SW + $clog2(N) + 1;
  localparam int CW = $clog2(N + 1);
  localparam longint unsigned RECIP_L = (64'd1 << KS) / N + 64'd1;
  localparam logic [KS:0]     RECIP   = RECIP_L[KS:0];
  localparam logic [IW-1:0]   FIRST_I = IW'(FIRST);
  localparam logic [IW-1:0]   LAST_I  = IW'(FIRST + 2 * (N - 1));
  localparam logic [CW-1:0]   N_C     = CW'(N);
  localparam logic [CW-1:0]   NM1_C   = CW'(N - 1);

  logic [SW-1:0]    sum_q, sum_n, base_sum;
  logic [CW-1:0]    cnt_q, cnt_n, base_cnt;
  logic             done_q, done_n;
  logic [DW-1:0]    blk_q, blk_n;
  logic             hit, take, fin, acc_en;
  logic [SW+KS:0]   prod;

  assign hit = i_valid && (i_idx >= FIRST_I) && (i_idx <= LAST_I);

  always_comb begin
    base_cnt = i_clr ? '0 : cnt_q;
    base_sum = i_clr ? '0 : sum_q;
    take     = hit && (base_cnt < N_C);
    fin      = take && (base_cnt == NM1_C);
    sum_n    = base_sum + (take ? SW'(i_data) : '0);
    cnt_n    = take ? base_cnt + 1'b1 : base_cnt;
    acc_en   = i_clr | take;
    done_n   = (i_clr ? 1'b0 : done_q) | fin;
    prod     = {{(KS+1){1'b0}}, sum_n} * {{SW{1'b0}}, RECIP};
    blk_n    = prod[KS +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      blk_q  <= '0;
    end else begin
      if (acc_en) begin
        sum_q <= sum_n;
        cnt_q <= cnt_n;
      end
      done_q <= done_n;
      if (fin) blk_q <= blk_n;
    end
  end

  assign o_blk  = blk_q;
  assign o_done = done_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= N_C); // R2
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(o_blk)); // R8
  AST_CLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (i_clr && (N > 1)) |=> !o_done); // R7
endmodule

// File: rtl/bl_pix_corr.sv
module bl_pix_corr #(
  parameter int DW   = 12,
  parameter int IW   = 13,
  parameter int LEAD = 74,
  parameter int EFF  = 5150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_valid,
  input  logic [IW-1:0] i_idx,
  input  logic [DW-1:0] i_data,
  input  logic [DW-1:0] i_blk,
  input  logic          i_gate,
  output logic          o_valid,
  output logic [IW-1:0] o_idx,
  output logic [DW-1:0] o_data
);
  localparam logic [IW-1:0] LEAD_I = IW'(LEAD);
  localparam logic [IW-1:0] LAST_I = IW'(LEAD + EFF);
  localparam logic [IW-1:0] EFF_I  = IW'(EFF);

  logic          eff, emit;
  logic [DW:0]   diff;
  logic [DW-1:0] corr_n;
  logic [IW-1:0] idx_n;
  logic          valid_q;
  logic [DW-1:0] data_q;
  logic [IW-1:0] idx_q;

  always_comb begin
    eff    = (i_idx > LEAD_I) && (i_idx <= LAST_I);
    emit   = i_valid && eff && i_gate;
    diff   = {1'b0, i_data} - {1'b0, i_blk};
    corr_n = diff[DW] ? '0 : diff[DW-1:0];
    idx_n  = i_idx - LEAD_I;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      idx_q   <= '0;
    end else begin
      valid_q <= emit;
      if (emit) begin
        data_q <= corr_n;
        idx_q  <= idx_n;
      end
    end
  end

  assign o_valid = valid_q;
  assign o_idx   = idx_q;
  assign o_data  = data_q;

  AST_EFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_idx >= IW'(1)) && (o_idx <= EFF_I)); // R3
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && !i_gate) |=> !o_valid); // R7
  AST_CLAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && (i_data <= i_blk)) |=> (!o_valid || (o_data == '0))); // R4
  AST_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid |=> (!o_valid || (o_data <= $past(i_data)))); // R4
endmodule

// File: rtl/bl_black_est.sv
module bl_black_est #(
  parameter int DW             = 12,
  parameter int IW             = 13,
  parameter int LEAD           = 74,
  parameter int EFF            = 5150,
  parameter int REF_N          = 10,
  parameter int REF_ODD_FIRST  = 5,
  parameter int REF_EVEN_FIRST = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          line_end,
  input  logic          odd_valid,
  input  logic [IW-1:0] odd_idx,
  input  logic [DW-1:0] odd_data,
  input  logic          even_valid,
  input  logic [IW-1:0] even_idx,
  input  logic [DW-1:0] even_data,
  output logic          odd_out_valid,
  output logic [IW-1:0] odd_out_idx,
  output logic [DW-1:0] odd_out_data,
  output logic          even_out_valid,
  output logic [IW-1:0] even_out_idx,
  output logic [DW-1:0] even_out_data,
  output logic [DW-1:0] odd_black,
  output logic [DW-1:0] even_black
);
  import bl_pkg::*;

  logic          rst_n_s;
  logic          in_line_q, in_line_n;
  logic          gate;
  logic          in_v   [NCH];
  logic [IW-1:0] in_idx [NCH];
  logic [DW-1:0] in_dat [NCH];
  logic          acc_v  [NCH];
  logic [DW-1:0] blk    [NCH];
  logic          done   [NCH];
  logic          out_v  [NCH];
  logic [IW-1:0] out_i  [NCH];
  logic [DW-1:0] out_d  [NCH];

  bl_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign in_v[0]   = odd_valid;
  assign in_idx[0] = odd_idx;
  assign in_dat[0] = odd_data;
  assign in_v[1]   = even_valid;
  assign in_idx[1] = even_idx;
  assign in_dat[1] = even_data;

  always_comb begin
    if (line_start)    in_line_n = 1'b1;
    else if (line_end) in_line_n = 1'b0;
    else               in_line_n = in_line_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) in_line_q <= 1'b0;
    else          in_line_q <= in_line_n;
  end

  assign gate = done[0] & done[1] & ~line_start;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam chan_e CH    = (c == 0) ? CH_ODD : CH_EVEN;
    localparam logic  PAR   = chan_parity(CH);
    localparam int    FIRST = (c == 0) ? REF_ODD_FIRST : REF_EVEN_FIRST;

    assign acc_v[c] = in_v[c] & (line_start | in_line_q) & (in_idx[c][0] == PAR);

    bl_ref_acc #(.DW(DW), .IW(IW), .N(REF_N), .FIRST(FIRST)) i_acc (
      .clk(clk), .rst_n(rst_n_s), .i_clr(line_start), .i_valid(acc_v[c]),
      .i_idx(in_idx[c]), .i_data(in_dat[c]), .o_blk(blk[c]), .o_done(done[c])
    );

    bl_pix_corr #(.DW(DW), .IW(IW), .LEAD(LEAD), .EFF(EFF)) i_corr (
      .clk(clk), .rst_n(rst_n_s), .i_valid(acc_v[c]), .i_idx(in_idx[c]),
      .i_data(in_dat[c]), .i_blk(blk[c]), .i_gate(gate),
      .o_valid(out_v[c]), .o_idx(out_i[c]), .o_data(out_d[c])
    );
  end

  assign odd_out_valid  = out_v[0];
  assign odd_out_idx    = out_i[0];
  assign odd_out_data   = out_d[0];
  assign even_out_valid = out_v[1];
  assign even_out_idx   = out_i[1];
  assign even_out_data  = out_d[1];
  assign odd_black      = blk[0];
  assign even_black     = blk[1];

  AST_CLOSED_LINE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!in_line_q && !line_start) |=> (!odd_out_valid && !even_out_valid)); // R9
  AST_PARITY_OUT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (odd_valid && !odd_idx[0]) |=> !odd_out_valid); // R6
endmodule

// File: tb/test_bl_black_est.sv
`timescale 1ns/1ps
module test_bl_black_est;
  localparam int DW = 12;
  localparam int IW = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          line_start, line_end;
  logic          ov, ev;
  logic [IW-1:0] oi, ei;
  logic [DW-1:0] od, ed;
  logic          odd_out_valid, even_out_valid;
  logic [IW-1:0] odd_out_idx, even_out_idx;
  logic [DW-1:0] odd_out_data, even_out_data, odd_black, even_black;

  always #2 clk = ~clk;

  bl_black_est i_bl_black_est (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_end(line_end),
    .odd_valid(ov), .odd_idx(oi), .odd_data(od),
    .even_valid(ev), .even_idx(ei), .even_data(ed),
    .odd_out_valid(odd_out_valid), .odd_out_idx(odd_out_idx), .odd_out_data(odd_out_data),
    .even_out_valid(even_out_valid), .even_out_idx(even_out_idx), .even_out_data(even_out_data),
    .odd_black(odd_black), .even_black(even_black)
  );

  // line table: reference base [31:20], reference spread [19:12], seed [11:4]
  localparam logic [31:0] LINE_TAB [5] = '{
    {12'd64,   8'd32,  8'd3,  4'd0},
    {12'd4000, 8'd80,  8'd5,  4'd0},
    {12'd0,    8'd1,   8'd7,  4'd0},
    {12'd2048, 8'd255, 8'd11, 4'd0},
    {12'd1000, 8'd200, 8'd13, 4'd0}
  };

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R3";

  bit m_in_line;
  bit m_done [2];
  int m_cnt  [2];
  int m_sum  [2];
  int m_blk  [2];
  bit x_valid[2];
  int x_data [2];
  int x_idx  [2];
  bit blk_chg[2];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gen(input int base, input int spread, input int seed, input int p);
    if (p >= 5 && p <= 24) return (base + (p * seed * 7) % spread) % 4096;
    return (p * seed * 37 + seed * 101 + p * p) % 4096;
  endfunction

  task automatic check_outputs();
    int av[2], ad[2], ai[2], ab[2];
    av[0] = int'(odd_out_valid);  ad[0] = int'(odd_out_data);  ai[0] = int'(odd_out_idx);  ab[0] = int'(odd_black);
    av[1] = int'(even_out_valid); ad[1] = int'(even_out_data); ai[1] = int'(even_out_idx); ab[1] = int'(even_black);
    for (int c = 0; c < 2; c++) begin
      chk(av[c] == int'(x_valid[c]), cur_req, av[c], int'(x_valid[c]));
      if (x_valid[c]) begin
        chk(ad[c] == x_data[c], "R4", ad[c], x_data[c]);
        chk(ai[c] == x_idx[c], "R3", ai[c], x_idx[c]);
      end
      chk(ab[c] == m_blk[c], blk_chg[c] ? "R10" : "R2", ab[c], m_blk[c]);
    end
  endtask

  task automatic model_chan(input int c, input bit ls, input bit v, input int p, input int d, input bit gate);
    bit acc;
    int first;
    acc   = v && (ls || m_in_line) && ((p % 2) == ((c == 0) ? 1 : 0));
    first = (c == 0) ? 5 : 6;
    x_valid[c] = acc && (p >= 75) && (p <= 5224) && gate;
    x_data[c]  = (d > m_blk[c]) ? d - m_blk[c] : 0;
    x_idx[c]   = p - 74;
    blk_chg[c] = 1'b0;
    if (ls) begin
      m_sum[c] = 0; m_cnt[c] = 0; m_done[c] = 1'b0;
    end
    if (acc && p >= first && p <= first + 18 && m_cnt[c] < 10) begin
      m_sum[c] += d;
      m_cnt[c]++;
      if (m_cnt[c] == 10) begin
        m_blk[c]   = m_sum[c] / 10;
        m_done[c]  = 1'b1;
        blk_chg[c] = 1'b1;
      end
    end
  endtask

  task automatic step(input bit ls, input bit le, input bit v0, input int p0, input int d0,
                      input bit v1, input int p1, input int d1);
    bit gate;
    @(negedge clk);
    check_outputs();
    line_start = ls; line_end = le;
    ov = v0; oi = IW'(p0); od = DW'(d0);
    ev = v1; ei = IW'(p1); ed = DW'(d1);
    gate = m_done[0] && m_done[1] && !ls;
    model_chan(0, ls, v0, p0, d0, gate);
    model_chan(1, ls, v1, p1, d1, gate);
    if (ls)      m_in_line = 1'b1;
    else if (le) m_in_line = 1'b0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic run_line(input int base, input int spread, input int seed, input int ncyc, input bit do_end);
    for (int k = 0; k < ncyc; k++)
      step(k == 0, do_end && (k == ncyc - 1),
           1, 2*k + 1, gen(base, spread, seed, 2*k + 1),
           1, 2*k + 2, gen(base, spread, seed, 2*k + 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int sv_o, sv_e, eo, ee;
    rst_n = 1'b0; line_start = 0; line_end = 0;
    ov = 0; oi = '0; od = '0; ev = 0; ei = '0; ed = '0;
    m_in_line = 0;
    for (int c = 0; c < 2; c++) begin
      m_done[c] = 0; m_cnt[c] = 0; m_sum[c] = 0; m_blk[c] = 0;
      x_valid[c] = 0; x_data[c] = 0; x_idx[c] = 0; blk_chg[c] = 0;
    end
    repeat (3) @(negedge clk);
    chk(odd_out_valid == 1'b0 && even_out_valid == 1'b0, "R1", int'(odd_out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(odd_out_valid == 1'b0, "R1", int'(odd_out_valid), 0);
    chk(even_out_valid == 1'b0, "R1", int'(even_out_valid), 0);
    chk(odd_black == '0, "R1", int'(odd_black), 0);
    chk(even_black == '0, "R1", int'(even_black), 0);

    // table of full lines: levels, correction, clamping, trailing dummies
    cur_req = "R5";
    for (int i = 0; i < 5; i++) begin
      run_line(int'(LINE_TAB[i][31:20]), int'(LINE_TAB[i][19:12]), int'(LINE_TAB[i][11:4]), 2622, 1);
      idle();
    end

    // R8: truncated line keeps previous levels
    sv_o = int'(odd_black); sv_e = int'(even_black);
    cur_req = "R8";
    run_line(500, 10, 2, 6, 1);
    idle(); idle();
    chk(int'(odd_black) == sv_o, "R8", int'(odd_black), sv_o);
    chk(int'(even_black) == sv_e, "R8", int'(even_black), sv_e);

    // R7: new line with no reference samples emits no effective pixel
    cur_req = "R7";
    step(1, 0, 1, 1, 10, 1, 2, 10);
    for (int k = 37; k < 43; k++) step(0, 0, 1, 2*k + 1, 3000, 1, 2*k + 2, 3000);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    idle();
    chk(odd_out_valid == 1'b0, "R7", int'(odd_out_valid), 0);

    // R9: samples with no open line are ignored
    cur_req = "R9";
    for (int k = 2; k < 12; k++) step(0, 0, 1, 2*k + 1, 4095, 1, 2*k + 2, 4095);
    for (int k = 37; k < 41; k++) step(0, 0, 1, 2*k + 1, 4000, 1, 2*k + 2, 4000);
    idle();
    chk(int'(odd_black) == sv_o, "R9", int'(odd_black), sv_o);
    chk(int'(even_black) == sv_e, "R9", int'(even_black), sv_e);

    // R6: swapped parity samples are ignored
    cur_req = "R6";
    step(1, 0, 1, 6, 4095, 1, 5, 4095);
    for (int k = 4; k <= 12; k++) step(0, 0, 1, 2*k, 4095, 1, 2*k - 1, 4095);
    for (int k = 2; k < 12; k++)
      step(0, 0, 1, 2*k + 1, gen(300, 20, 4, 2*k + 1), 1, 2*k + 2, gen(300, 20, 4, 2*k + 2));
    idle();
    eo = 0; ee = 0;
    for (int p = 5; p <= 23; p += 2) eo += gen(300, 20, 4, p);
    for (int p = 6; p <= 24; p += 2) ee += gen(300, 20, 4, p);
    chk(int'(odd_black) == eo / 10, "R6", int'(odd_black), eo / 10);
    chk(int'(even_black) == ee / 10, "R6", int'(even_black), ee / 10);
    cur_req = "R3";
    step(0, 0, 1, 75, 4095, 1, 76, 100);
    step(0, 0, 1, 5223, 200, 1, 5224, 4095);

    // R5: positions that carry no effective pixel, and late reference repeats
    cur_req = "R5";
    step(0, 0, 1, 7, 4095, 1, 8, 4095);
    step(0, 0, 1, 1, 4095, 1, 2, 4095);
    step(0, 0, 1, 73, 4095, 1, 74, 4095);
    step(0, 0, 1, 5225, 4095, 1, 5226, 4095);
    step(0, 0, 1, 5243, 4095, 1, 5244, 4095);
    step(0, 0, 1, 5245, 4095, 1, 0, 4095);
    step(0, 0, 1, 8191, 4095, 1, 8190, 4095);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    idle();
    chk(int'(odd_black) == eo / 10, "R5", int'(odd_black), eo / 10);
    chk(even_out_valid == 1'b0, "R5", int'(even_out_valid), 0);
    idle();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule